// File: doc/BRIEF.md
# Interleaved Dual-Bank FIFO

A first-in first-out buffer on a single clock. Its storage is two single-port RAM banks, and each bank can take either one read or one write in a cycle. Consecutive entries go to alternating banks. A two-slot prefetch stage sits in front of the read port. It pulls the next unread word out of RAM, and only ever from the bank that is not taking a write in that cycle. Because no bank is ever asked to read and write at once, a push and a pop can both complete in the same cycle.

The producer drives a push strobe with data and watches `full`. The consumer sees the oldest word on `rd_data` whenever `empty` is low, and pops it with `rd_req`. `count` reports every word accepted and not yet popped, including words still travelling from RAM into the prefetch stage. The total depth is a parameter. It must be an even power of two, at least 4 and at most 512, and it is split evenly across the two banks.

Top module: `ilv_fifo`

## Requirements
- R1: While `rst_n` is low and just after it is released, `empty` is 1, `full` is 0 and `count` is 0.
- R2: Words leave on `rd_data` in the order they were accepted, with no loss and no duplication.
- R3: When `empty` is low, `rd_data` already holds the oldest word. A pop at a clock edge takes that word and adds no latency. `empty` is always 1 when `count` is 0.
- R4: A word pushed into an empty FIFO at one clock edge appears on `rd_data`, with `empty` low, after the second clock edge that follows it.
- R5: Entry k is written to bank k mod 2 at row k/2. In any cycle a bank is either read or written, never both, and at most one bank is written.
- R6: `count` equals the accepted pushes minus the accepted pops. `full` is 1 exactly when `count` equals the depth.
- R7: A push while `full` is 1 and no pop is accepted is ignored. `count` and `full` keep their values and the stored contents are unchanged.
- R8: A pop while `empty` is 1 is ignored. `count` keeps its value and no word is consumed.
- R9: A push together with an accepted pop while full is accepted. `count` stays at the depth and the new word is queued behind the remaining ones.
- R10: Under continuous pushes and pops across many cycles, including bank conflicts that delay a prefetch, every word still arrives intact and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_req | input | 1 | Push strobe |
| wr_data | input | DW | Word to push |
| rd_req | input | 1 | Pop strobe |
| rd_data | output | DW | Oldest word, valid while `empty` is low |
| full | output | 1 | No room for a push without a pop |
| empty | output | 1 | No word ready at the read port |
| count | output | $clog2(DEPTH+1) | Words held, including those in flight to the prefetch stage |

## Verification
The hardest case to reach is a prefetch that gets held back because the next unread entry sits in the bank that the current push is writing. That only happens when a push arrives in the same cycle as a fetch and the unread words in RAM number an even, nonzero amount. The stimulus gets there by filling the FIFO, letting the prefetch stage fill up, and then pushing and popping in every cycle for a long stretch, so that the RAM occupancy passes through even values many times while data order is checked on every pop. A second hard case is a pop attempted while `count` is nonzero but the word is still in flight. A push followed at once by a pop reaches it.

// File: rtl/ilv_fifo_pkg.sv
// Package: shared types for the interleaved dual-bank FIFO.
// Assumes nothing beyond IEEE 1800-2017 enums.
package ilv_fifo_pkg;

    // Operation applied to the prefetch stage in one cycle.
    typedef enum logic [1:0] {
        PF_IDLE = 2'b00,
        PF_POP  = 2'b01,
        PF_LOAD = 2'b10,
        PF_BOTH = 2'b11
    } pf_op_e;

endpackage

// File: rtl/ilv_bank.sv
// Module: ilv_bank
// Single-port synchronous RAM model. One access per cycle: a write when
// we is high, otherwise a read when en is high. Read data is registered
// and holds its value until the next read.
// Assumes the caller never requests a read and a write in the same cycle.
module ilv_bank #(
    parameter int DW   = 8,
    parameter int ROWS = 8,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [RW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [ROWS];

    // Single port: write or registered read, chosen by we.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/ilv_prefetch.sv
// Module: ilv_prefetch
// Two-slot output buffer. Slot 0 is the head shown to the read port.
// Loads arrive from RAM and pops come from the consumer, and both may
// happen in the same cycle.
// Assumes a load never arrives while both slots are full unless a pop
// occurs in that cycle, and a pop never arrives while the stage is empty.
module ilv_prefetch
    import ilv_fifo_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          valid,
    output logic [1:0]    occ
);

    logic [DW-1:0] slot0, slot1;
    pf_op_e        op;

    // Encode this cycle's operation.
    always_comb op = pf_op_e'({load, pop});

    // Occupancy tracking with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= 2'd0;
        end else begin
            case (op)
                PF_POP:  occ <= occ - 2'd1;
                PF_LOAD: occ <= occ + 2'd1;
                default: occ <= occ;
            endcase
        end
    end

    // Data slots: shift on pop and fill the first free slot on load.
    always_ff @(posedge clk) begin
        case (op)
            PF_POP: slot0 <= slot1;
            PF_LOAD: begin
                if (occ == 2'd0) slot0 <= load_data;
                else             slot1 <= load_data;
            end
            PF_BOTH: begin
                if (occ == 2'd1) begin
                    slot0 <= load_data;
                end else begin
                    slot0 <= slot1;
                    slot1 <= load_data;
                end
            end
            default: ;
        endcase
    end

    assign head  = slot0;
    assign valid = (occ != 2'd0);

endmodule

// File: rtl/ilv_fifo.sv
// Module: ilv_fifo (top)
// Single-clock FIFO on two single-port banks. Entry k goes to bank k%2,
// row k/2. A fetch pointer reads unread entries into a two-slot prefetch
// stage, but never from the bank being written in the same cycle.
// Assumes DEPTH is an even power of two, 4 <= DEPTH <= 512.
module ilv_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_req,
    input  logic [DW-1:0]                wr_data,
    input  logic                         rd_req,
    output logic [DW-1:0]                rd_data,
    output logic                         full,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);

    localparam int ROWS = DEPTH / 2;
    localparam int PW   = $clog2(DEPTH);
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic [PW-1:0] wptr, fptr;
    logic [CW-1:0] cnt_q, ram_cnt;
    logic          pend_q, pend_bank_q;
    logic          wr_acc, rd_acc, fetch, slot_free, pf_valid;
    logic [1:0]    pf_occ;
    logic [2:0]    pf_need;
    logic [1:0]    bk_we, bk_re;
    logic [DW-1:0] bk_rdata [2];

    // Acceptance of push and pop at the ports.
    always_comb begin
        rd_acc = rd_req && pf_valid;
        wr_acc = wr_req && (!full || rd_acc);
    end

    // Fetch decision: free slot, unread entry in RAM, and no bank clash.
    always_comb begin
        pf_need   = {1'b0, pf_occ} + {2'b00, pend_q} - {2'b00, rd_acc};
        slot_free = (pf_need < 3'd2);
        fetch     = (ram_cnt != '0) && slot_free &&
                    !(wr_acc && (wptr[0] == fptr[0]));
    end

    // Two banks, each driven by its own write or fetch strobe.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [RW-1:0] addr_b;

        // Port steering: a write takes priority over the address mux.
        always_comb begin
            bk_we[b] = wr_acc && (wptr[0] == 1'(b));
            bk_re[b] = fetch  && (fptr[0] == 1'(b));
            addr_b   = bk_we[b] ? RW'(wptr[PW-1:1]) : RW'(fptr[PW-1:1]);
        end

        ilv_bank #(.DW(DW), .ROWS(ROWS)) u_bank (
            .clk   (clk),
            .en    (bk_we[b] | bk_re[b]),
            .we    (bk_we[b]),
            .addr  (addr_b),
            .wdata (wr_data),
            .rdata (bk_rdata[b])
        );
    end

    // Pointers, counters and the in-flight read marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr        <= '0;
            fptr        <= '0;
            ram_cnt     <= '0;
            cnt_q       <= '0;
            pend_q      <= 1'b0;
            pend_bank_q <= 1'b0;
        end else begin
            wptr        <= wptr + PW'(wr_acc);
            fptr        <= fptr + PW'(fetch);
            ram_cnt     <= ram_cnt + CW'(wr_acc) - CW'(fetch);
            cnt_q       <= cnt_q + CW'(wr_acc) - CW'(rd_acc);
            pend_q      <= fetch;
            pend_bank_q <= fptr[0];
        end
    end

    ilv_prefetch #(.DW(DW)) u_pf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pend_q),
        .load_data (bk_rdata[pend_bank_q]),
        .pop       (rd_acc),
        .head      (rd_data),
        .valid     (pf_valid),
        .occ       (pf_occ)
    );

    assign full  = (cnt_q == FULL_LVL);
    assign empty = !pf_valid;
    assign count = cnt_q;

endmodule

// File: rtl/ilv_fifo_chk.sv
// Module: ilv_fifo_chk
// Property checker for ilv_fifo, attached to every instance by bind.
// Assumes the bank strobes bk_we and bk_re are visible in the top scope.
module ilv_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_req,
    input logic          rd_req,
    input logic          full,
    input logic          empty,
    input logic [CW-1:0] count,
    input logic [1:0]    bk_we,
    input logic [1:0]    bk_re
);

    a_r5_bank0_single: assert property (@(posedge clk) disable iff (!rst_n)
        !(bk_we[0] && bk_re[0]));

    a_r5_bank1_single: assert property (@(posedge clk) disable iff (!rst_n)
        !(bk_we[1] && bk_re[1]));

    a_r5_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bk_we));

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    a_r6_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && wr_req && !rd_req) |=> (count == $past(count) + CW'(1)));

    a_r3_zero_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> empty);

    a_r7_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !rd_req) |=> (full && count == $past(count)));

    a_r8_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req && !wr_req) |=> (count == $past(count)));

    a_r9_full_both_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && rd_req) |=> full);

endmodule

bind ilv_fifo ilv_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_req (wr_req),
    .rd_req (rd_req),
    .full   (full),
    .empty  (empty),
    .count  (count),
    .bk_we  (bk_we),
    .bk_re  (bk_re)
);

// File: tb/sim_ilv_fifo.sv
// Bench: directed scenarios against a queue model of the FIFO.
module sim_ilv_fifo;

    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_req, rd_req;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;
    logic          full, empty;
    logic [CW-1:0] count;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic [DW-1:0] mq [$];

    ilv_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data), .full(full), .empty(empty),
        .count(count)
    );

    always #10 clk = ~clk;

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One cycle: drive at a falling edge, let the rising edge act, return at the next falling edge.
    task automatic cycle(input bit w, input logic [DW-1:0] d, input bit r, input string tag);
        bit racc, wacc;
        racc = r && !empty;
        wacc = w && (!full || racc);
        if (racc) begin
            chk(tag, rd_data, mq[0]);
            void'(mq.pop_front());
        end
        if (wacc) mq.push_back(d);
        wr_req  = w;
        wr_data = d;
        rd_req  = r;
        @(negedge clk);
        wr_req = 1'b0;
        rd_req = 1'b0;
        chk("R6 count", count, mq.size());
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, '0, 1'b0, "R6");
    endtask

    task automatic drain(input string tag);
        while (mq.size() != 0) cycle(1'b0, '0, 1'b1, tag);
        idle(3);
        chk({tag, " empty after drain"}, empty, 1'b1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; wr_req = 1'b0; rd_req = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 empty", empty, 1'b1);
        chk("R1 full", full, 1'b0);
        chk("R1 count", count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 empty after release", empty, 1'b1);
        chk("R1 count after release", count, 0);
    endtask

    task automatic t_latency;
        cycle(1'b1, 8'hA5, 1'b0, "R4");
        chk("R4 empty one edge after", empty, 1'b1);
        @(negedge clk);
        chk("R4 empty still high", empty, 1'b1);
        @(negedge clk);
        chk("R4 empty low two edges after", empty, 1'b0);
        chk("R3 head shown", rd_data, 8'hA5);
        drain("R3 pop");
    endtask

    task automatic t_empty_pop;
        cycle(1'b0, '0, 1'b1, "R8");
        cycle(1'b0, '0, 1'b1, "R8");
        chk("R8 empty kept", empty, 1'b1);
        chk("R8 count kept", count, 0);
        cycle(1'b1, 8'h3C, 1'b0, "R8");
        cycle(1'b0, '0, 1'b1, "R8");
        chk("R8 in-flight pop ignored", count, 1);
        idle(3);
        chk("R8 word kept", rd_data, 8'h3C);
        drain("R8");
    endtask

    task automatic t_full_push;
        for (int i = 0; i < DEPTH; i++) cycle(1'b1, DW'(i * 7 + 3), 1'b0, "R6");
        chk("R6 full at depth", full, 1'b1);
        idle(4);
        cycle(1'b1, 8'hEE, 1'b0, "R7");
        cycle(1'b1, 8'hEE, 1'b0, "R7");
        chk("R7 full kept", full, 1'b1);
        chk("R7 count kept", count, DEPTH);
        drain("R7 contents");
        chk("R6 not full when drained", full, 1'b0);
    endtask

    task automatic t_full_both;
        for (int i = 0; i < DEPTH; i++) cycle(1'b1, DW'(8'h80 + i), 1'b0, "R9");
        idle(4);
        cycle(1'b1, 8'h55, 1'b1, "R9");
        chk("R9 count at depth", count, DEPTH);
        chk("R9 still full", full, 1'b1);
        cycle(1'b1, 8'h56, 1'b1, "R9");
        drain("R9 order");
    endtask

    task automatic t_stream;
        for (int i = 0; i < 6; i++) cycle(1'b1, DW'(8'h40 + i), 1'b0, "R10");
        idle(4);
        for (int i = 0; i < 300; i++) cycle(1'b1, DW'(i * 13 + 1), 1'b1, "R10");
        for (int i = 0; i < 200; i++) cycle(i % 3 != 0, DW'(i * 5), i % 2 == 0, "R2");
        drain("R5 interleaved order");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_empty_pop();
        t_full_push();
        t_full_both();
        t_stream();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule